// File: doc/BRIEF.md
# Deflection Node Decision Controller

This block is the electronic routing decision for one two-input, two-output node of a cylindrical, bufferless switch fabric that works in synchronous timeslots. Nodes sit on concentric cylinders. A packet that resolves one more destination bit moves inward (south) to the next cylinder at the same height. A packet that does not resolve that bit is deflected sideways (east) within its own cylinder. The optical gates and the wiring between heights are outside the block. The controller only produces the pair of gate enables and a backpressure flag.

Each node knows its cylinder index, its height and its angle value through parameters. The node has two inputs, each with a frame bit and an address header. The west input comes from the same cylinder and the north input from the outer cylinder. The west input wins when both are framed, because the node's own backpressure output is meant to keep the outer neighbour quiet whenever the east path is busy. Outside the innermost cylinder, the node compares one address bit against one bit of its height. A block flag from the inner cylinder forces deflection. On the innermost cylinder the node compares the low angle field instead, so packets keep circulating until they reach their own angle position.

The decision is held in a three-state machine: ST_IDLE (no packet), ST_INGRESS (south gate open) and ST_DEFLECT (east gate open). On every slot tick the machine moves to the state the sampled header selects, from any state. Between ticks it stays in its state.

Top module: `defl_node_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, and before the first slot tick, gate_en is 2'b00 and defl_out is 0.
- R2: A slot tick with neither west_frame nor north_frame set leads to ST_IDLE: gate_en is 2'b00 and defl_out is 0 for that slot.
- R3: When both frames are set at a slot tick, the west header decides the route and the north header has no effect. The north header is used only when west_frame is clear.
- R4: Outside the innermost cylinder (CYL_IDX < NUM_CYL-1), header bit addr[ADDR_W-1-CYL_IDX] is compared with height bit HEIGHT[NUM_CYL-2-CYL_IDX]. On equality with block_in low, the south enable gate_en[0] is set.
- R5: Outside the innermost cylinder, inequality of those two bits sets the east enable gate_en[1].
- R6: Outside the innermost cylinder, block_in high at a framed slot tick forces the east enable, even when the bits are equal.
- R7: On the innermost cylinder, the node sets gate_en[0] when addr[ANGLE_BITS-1:0] equals ANGLE_VAL and sets gate_en[1] otherwise. block_in has no effect there.
- R8: defl_out is high exactly in the slots where gate_en[1] is high.
- R9: gate_en and defl_out change only on a clock edge where slot_tick is high. Input changes between ticks have no effect.
- R10: gate_en[1] and gate_en[0] are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | High for one cycle at each slot boundary; headers are sampled then |
| west_frame | input | 1 | Packet present on the same-cylinder input |
| west_addr | input | ADDR_W | Header address of the same-cylinder input |
| north_frame | input | 1 | Packet present on the outer-cylinder input |
| north_addr | input | ADDR_W | Header address of the outer-cylinder input |
| block_in | input | 1 | Inner-cylinder node refuses ingress this slot |
| gate_en | output | 2 | {east enable, south enable} for the whole slot |
| defl_out | output | 1 | Backpressure toward the outer-cylinder node |

## Verification
Each decision is registered once. The outputs for a slot are due on the same clock edge where slot_tick is sampled high. The bench drives the header and the tick on a falling edge, lets one rising edge pass and compares at the following falling edge. It then changes every input while slot_tick is low and, two edges later, checks that the outputs still show the earlier decision. Two instances run the sweep together: one on an outer cylinder and one on the innermost cylinder.

// File: rtl/defl_pkg.sv
package defl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_INGRESS = 2'd1,
        ST_DEFLECT = 2'd2
    } node_state_e;

    localparam int GATE_SOUTH = 0;
    localparam int GATE_EAST  = 1;
endpackage

// File: rtl/defl_port_sel.sv
module defl_port_sel #(
    parameter int ADDR_W = 4
) (
    input  logic              west_frame,
    input  logic [ADDR_W-1:0] west_addr,
    input  logic              north_frame,
    input  logic [ADDR_W-1:0] north_addr,
    output logic              pkt_valid,
    output logic [ADDR_W-1:0] pkt_addr
);
    // Same-cylinder traffic wins; the outer node is told to hold off via defl_out.
    always_comb begin
        pkt_valid = west_frame | north_frame;
        pkt_addr  = west_frame ? west_addr : north_addr;
    end
endmodule

// File: rtl/defl_route_cmp.sv
module defl_route_cmp #(
    parameter int NUM_CYL    = 3,
    parameter int CYL_IDX    = 1,
    parameter int HEIGHT     = 2,
    parameter int ANGLE_BITS = 2,
    parameter int ANGLE_VAL  = 1,
    localparam int HBITS     = NUM_CYL - 1,
    localparam int ADDR_W    = HBITS + ANGLE_BITS
) (
    input  logic [ADDR_W-1:0] pkt_addr,
    input  logic              block_in,
    output logic              want_south
);
    localparam logic [ANGLE_BITS-1:0] ANGLE_CODE = ANGLE_BITS'(ANGLE_VAL);

    generate
        if (CYL_IDX == NUM_CYL - 1) begin : g_inner
            logic unused_inner;
            assign unused_inner = ^{pkt_addr, block_in};
            assign want_south   = (pkt_addr[ANGLE_BITS-1:0] == ANGLE_CODE);
        end else begin : g_outer
            localparam logic [HBITS-1:0] HCODE = HBITS'(HEIGHT);
            logic addr_bit;
            logic height_bit;
            assign addr_bit   = pkt_addr[ADDR_W-1-CYL_IDX];
            assign height_bit = HCODE[HBITS-1-CYL_IDX];
            assign want_south = (addr_bit == height_bit) && !block_in;
        end
    endgenerate
endmodule

// File: rtl/defl_slot_fsm.sv
module defl_slot_fsm
    import defl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_tick,
    input  logic       pkt_valid,
    input  logic       want_south,
    output logic [1:0] gate_en,
    output logic       defl_out
);
    node_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (slot_tick) begin
            if (!pkt_valid)      state_d = ST_IDLE;
            else if (want_south) state_d = ST_INGRESS;
            else                 state_d = ST_DEFLECT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        gate_en  = 2'b00;
        defl_out = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_INGRESS: gate_en[GATE_SOUTH] = 1'b1;
            ST_DEFLECT: begin
                gate_en[GATE_EAST] = 1'b1;
                defl_out           = 1'b1;
            end
            default:    ;
        endcase
    end

    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_en) <= 1); // R10
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(gate_en) && $stable(defl_out)); // R9
    AST_DEFL_WITH_EAST: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick && pkt_valid && !want_south |=> defl_out && gate_en[GATE_EAST]); // R8
endmodule

// File: rtl/defl_node_ctrl.sv
module defl_node_ctrl #(
    parameter int NUM_CYL    = 3,
    parameter int CYL_IDX    = 1,
    parameter int HEIGHT     = 2,
    parameter int ANGLE_BITS = 2,
    parameter int ANGLE_VAL  = 1,
    localparam int ADDR_W    = NUM_CYL - 1 + ANGLE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic              west_frame,
    input  logic [ADDR_W-1:0] west_addr,
    input  logic              north_frame,
    input  logic [ADDR_W-1:0] north_addr,
    input  logic              block_in,
    output logic [1:0]        gate_en,
    output logic              defl_out
);
    logic              pkt_valid;
    logic [ADDR_W-1:0] pkt_addr;
    logic              want_south;

    defl_port_sel #(.ADDR_W(ADDR_W)) u_sel (
        .west_frame (west_frame),
        .west_addr  (west_addr),
        .north_frame(north_frame),
        .north_addr (north_addr),
        .pkt_valid  (pkt_valid),
        .pkt_addr   (pkt_addr)
    );

    defl_route_cmp #(
        .NUM_CYL   (NUM_CYL),
        .CYL_IDX   (CYL_IDX),
        .HEIGHT    (HEIGHT),
        .ANGLE_BITS(ANGLE_BITS),
        .ANGLE_VAL (ANGLE_VAL)
    ) u_cmp (
        .pkt_addr  (pkt_addr),
        .block_in  (block_in),
        .want_south(want_south)
    );

    defl_slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_tick (slot_tick),
        .pkt_valid (pkt_valid),
        .want_south(want_south),
        .gate_en   (gate_en),
        .defl_out  (defl_out)
    );

    AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick && !west_frame && !north_frame |=> gate_en == 2'b00 && !defl_out); // R2

    generate
        if (CYL_IDX == NUM_CYL - 1) begin : g_chk_inner
            AST_INNER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
                slot_tick && west_frame && (west_addr[ANGLE_BITS-1:0] == ANGLE_BITS'(ANGLE_VAL))
                |=> gate_en[0]); // R7
        end else begin : g_chk_outer
            AST_BLOCK_FORCES_EAST: assert property (@(posedge clk) disable iff (!rst_n)
                slot_tick && block_in && (west_frame || north_frame) |=> !gate_en[0]); // R6
        end
    endgenerate
endmodule

// File: tb/defl_node_ctrl_tb.sv
module defl_node_ctrl_tb;
    localparam int NC = 3;
    localparam int AB = 2;
    localparam int AW = NC - 1 + AB;
    localparam int HB = NC - 1;
    localparam int O_CYL = 1, O_HGT = 2, O_ANG = 3;
    localparam int I_CYL = 2, I_HGT = 1, I_ANG = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_tick = 1'b0;
    logic west_frame = 1'b0, north_frame = 1'b0, block_in = 1'b0;
    logic [AW-1:0] west_addr = '0, north_addr = '0;
    logic [1:0] gate_o, gate_i;
    logic defl_o, defl_i;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    defl_node_ctrl #(.NUM_CYL(NC), .CYL_IDX(O_CYL), .HEIGHT(O_HGT),
                     .ANGLE_BITS(AB), .ANGLE_VAL(O_ANG)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .west_frame(west_frame), .west_addr(west_addr),
        .north_frame(north_frame), .north_addr(north_addr),
        .block_in(block_in), .gate_en(gate_o), .defl_out(defl_o));

    defl_node_ctrl #(.NUM_CYL(NC), .CYL_IDX(I_CYL), .HEIGHT(I_HGT),
                     .ANGLE_BITS(AB), .ANGLE_VAL(I_ANG)) u_dut_inner (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
        .west_frame(west_frame), .west_addr(west_addr),
        .north_frame(north_frame), .north_addr(north_addr),
        .block_in(block_in), .gate_en(gate_i), .defl_out(defl_i));

    // Returns {defl_out, gate_en[1], gate_en[0]}
    function automatic logic [2:0] ref_route(int cyl, int hgt, int ang,
                                             logic wf, logic [AW-1:0] wa,
                                             logic nf, logic [AW-1:0] na, logic blk);
        logic [AW-1:0] a;
        logic south;
        if (!wf && !nf) return 3'b000;                 // R2
        a = wf ? wa : na;                              // R3
        if (cyl == NC - 1)
            south = ((int'(a) % (1 << AB)) == ang);    // R7
        else
            south = (((int'(a) >> (AW - 1 - cyl)) & 1) == ((hgt >> (HB - 1 - cyl)) & 1))
                    && !blk;                           // R4 R5 R6
        return south ? 3'b001 : 3'b110;                // R8 R10
    endfunction

    task automatic check(string req, string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, tag, act, exp);
        end
    endtask

    function automatic string req_of(int cyl, logic wf, logic nf, logic blk);
        if (!wf && !nf)    return "R2";
        if (cyl == NC - 1) return "R7";
        if (wf && nf)      return "R3";
        if (blk)           return "R6";
        return "R4/R5";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset outer", {defl_o, gate_o}, 3'b000);
        check("R1", "reset inner", {defl_i, gate_i}, 3'b000);
        rst_n = 1'b1;
        west_frame = 1'b1; west_addr = '1;
        repeat (2) @(negedge clk);
        check("R1", "post-reset no tick outer", {defl_o, gate_o}, 3'b000);
        check("R1", "post-reset no tick inner", {defl_i, gate_i}, 3'b000);

        for (int k = 0; k < 8; k++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                logic wf, nf, blk;
                logic [2:0] eo, ei;
                wf = k[0]; nf = k[1]; blk = k[2];
                @(negedge clk);
                west_frame = wf; north_frame = nf; block_in = blk;
                west_addr = AW'(a); north_addr = ~AW'(a);
                slot_tick = 1'b1;
                eo = ref_route(O_CYL, O_HGT, O_ANG, wf, AW'(a), nf, ~AW'(a), blk);
                ei = ref_route(I_CYL, I_HGT, I_ANG, wf, AW'(a), nf, ~AW'(a), blk);
                @(negedge clk);
                slot_tick = 1'b0;
                check(req_of(O_CYL, wf, nf, blk), "outer route", {defl_o, gate_o}, eo);
                check(req_of(I_CYL, wf, nf, blk), "inner route", {defl_i, gate_i}, ei);
                // R9: scramble inputs without a tick; outputs must hold
                west_frame = ~wf; north_frame = ~nf; block_in = ~blk;
                west_addr = ~AW'(a); north_addr = AW'(a);
                repeat (2) @(negedge clk);
                check("R9", "outer hold", {defl_o, gate_o}, eo);
                check("R9", "inner hold", {defl_i, gate_i}, ei);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule